// File: doc/BRIEF.md
# Frame Rate Calibration Pre-Divider

This block derives a display frame rate from a clock whose frequency is not known at design time. Software raises a calibration enable, waits a known real time, then lowers it. The block counts the input clock cycles for which the enable was high and converts that count into a pre-divider ratio. The divided clock advances a frame counter, which produces one frame strobe for a fixed number of divided ticks. The frame rate is therefore the clock frequency divided by the product of the tick count per frame (1088 by default) and the ratio.

A calibration cannot start while the power-down flag or the partial-screen flag is set. If either flag rises during a window, the measurement is dropped. A result is held as pending and is copied into the active ratio only on a frame strobe, so every frame has a regular length. Other activity on the inputs does not affect a measurement in progress.

With the default rounding, a window of 64 cycles gives ratio 4. That is roughly a 190 µs window at 336 kHz, which yields about 77 Hz.

Top module: `frame_rate_cal`

## Requirements
- R1: After reset the ratio output is 4. No window is in progress. The divider and frame counters start at zero, so the first tick comes on the 4th clock and the first frame strobe on the FRAME_TICKS-th tick.
- R2: The ratio output always lies between 1 and 15 inclusive.
- R3: A window starts on a clock where cal_en is 1 after having been 0 on the previous clock. It ends on the first clock where cal_en is 0. If N is the number of clocks on which cal_en was 1, the new ratio is (N+8)/16 rounded down and clamped to 1..15. For example, 96 cycles gives 6 and 64 cycles gives 4.
- R4: A window shorter than 8 cycles gives ratio 1.
- R5: The window counter saturates at its all-ones value and never wraps. Any window of 248 cycles or more gives ratio 15.
- R6: A rising edge of cal_en on a clock where pwr_down or partial is 1 starts no window, and the ratio stays unchanged.
- R7: If pwr_down or partial is 1 on any clock of a running window, the window is aborted and the previous ratio is kept.
- R8: tick_o is 1 once every ratio clocks. frame_o is 1 on every FRAME_TICKS-th tick and only together with tick_o.
- R9: A computed ratio appears on ratio_o on the clock after the next frame strobe, and ratio_o changes at no other time.
- R10: If cal_en is already high when a blocking flag clears, no window starts; a fresh 0-to-1 edge is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the oscillator or an external source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration enable; its high time is measured |
| pwr_down | input | 1 | Power-down flag; blocks and aborts calibration |
| partial | input | 1 | Partial-screen flag; blocks and aborts calibration |
| ratio_o | output | $clog2(RATIO_MAX+1) | Active pre-divider ratio |
| tick_o | output | 1 | Divided clock enable, one clock wide |
| frame_o | output | 1 | Frame strobe, one clock wide |

## Verification
The bench sets FRAME_TICKS to 4, so that a frame boundary comes within a few dozen clocks and the moment a ratio is handed over can be seen many times in one run. It also narrows the window counter to 9 bits, so a 600-cycle window drives the counter into saturation. A counter that wrapped would give ratio 6 there instead of the upper clamp of 15. The rounding threshold, the lower clamp and the abort and ignore paths are all reached with windows only a few cycles long.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_phase_e;

    // Half of the divisor used for round-to-nearest after a right shift.
    function automatic int unsigned round_bias(input int unsigned shift);
        return (shift == 0) ? 0 : (1 << (shift - 1));
    endfunction

endpackage

// File: rtl/frc_window.sv
module frc_window #(
    parameter int CNT_W     = 16,
    parameter int SHIFT     = 4,
    parameter int RATIO_MIN = 1,
    parameter int RATIO_MAX = 15,
    localparam int RW       = $clog2(RATIO_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_en,
    input  logic          blocked,
    output logic          done_o,
    output logic [RW-1:0] ratio_new_o
);
    import frc_pkg::*;

    localparam int SW = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_SAT = '1;
    localparam logic [SW-1:0] BIAS = SW'(round_bias(SHIFT));
    localparam logic [SW-1:0] LO   = SW'(RATIO_MIN);
    localparam logic [SW-1:0] HI   = SW'(RATIO_MAX);

    typedef struct packed {
        win_phase_e       phase;
        logic             en_prev;
        logic [CNT_W-1:0] cnt;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [SW-1:0] sum_w, quo_w;
    logic          done_w;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = cal_en;
        done_w       = 1'b0;
        sum_w        = {1'b0, st_q.cnt} + BIAS;
        quo_w        = sum_w >> SHIFT;
        if (quo_w < LO)      ratio_new_o = RW'(RATIO_MIN);
        else if (quo_w > HI) ratio_new_o = RW'(RATIO_MAX);
        else                 ratio_new_o = quo_w[RW-1:0];

        unique case (st_q.phase)
            WIN_IDLE: begin
                if (cal_en && !st_q.en_prev && !blocked) begin
                    st_d.phase = WIN_RUN;
                    st_d.cnt   = CNT_W'(1);
                end
            end
            WIN_RUN: begin
                if (blocked) begin
                    st_d.phase = WIN_IDLE;
                end else if (cal_en) begin
                    if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + CNT_W'(1);
                end else begin
                    st_d.phase = WIN_IDLE;
                    done_w     = 1'b1;
                end
            end
            default: st_d.phase = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: WIN_IDLE, en_prev: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = done_w;

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == WIN_RUN && $past(st_q.phase) == WIN_RUN) |-> (st_q.cnt >= $past(st_q.cnt))); // R5
    AST_BLOCK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> (st_q.phase == WIN_IDLE)); // R7
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cal_en && !blocked)); // R3

endmodule

// File: rtl/frc_prediv.sv
module frc_prediv #(
    parameter int RATIO_MAX = 15,
    localparam int RW       = $clog2(RATIO_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio,
    output logic          tick_o
);
    typedef struct packed {
        logic [RW-1:0] pdiv;
    } pd_st_t;

    pd_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.pdiv == ratio - RW'(1));
        if (tick_o) st_d.pdiv = '0;
        else        st_d.pdiv = st_q.pdiv + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PDIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pdiv < ratio); // R8

endmodule

// File: rtl/frc_frame.sv
module frc_frame #(
    parameter int FRAME_TICKS = 1088,
    localparam int FW         = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic frame_o
);
    localparam logic [FW-1:0] LAST = FW'(FRAME_TICKS - 1);

    typedef struct packed {
        logic [FW-1:0] fcnt;
    } fr_st_t;

    fr_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        frame_o = tick && (st_q.fcnt == LAST);
        if (tick) begin
            if (st_q.fcnt == LAST) st_d.fcnt = '0;
            else                   st_d.fcnt = st_q.fcnt + FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.fcnt)); // R8

endmodule

// File: rtl/frame_rate_cal.sv
module frame_rate_cal #(
    parameter int CNT_W       = 16,
    parameter int SHIFT       = 4,
    parameter int RATIO_MIN   = 1,
    parameter int RATIO_MAX   = 15,
    parameter int RATIO_RST   = 4,
    parameter int FRAME_TICKS = 1088,
    localparam int RW         = $clog2(RATIO_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_en,
    input  logic          pwr_down,
    input  logic          partial,
    output logic [RW-1:0] ratio_o,
    output logic          tick_o,
    output logic          frame_o
);
    typedef struct packed {
        logic [RW-1:0] ratio;
        logic [RW-1:0] pend;
        logic          pend_v;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          blocked_w;
    logic          done_w;
    logic [RW-1:0] ratio_new_w;
    logic          tick_w;
    logic          frame_w;

    assign blocked_w = pwr_down | partial;

    frc_window #(
        .CNT_W(CNT_W), .SHIFT(SHIFT),
        .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .blocked(blocked_w),
        .done_o(done_w), .ratio_new_o(ratio_new_w)
    );

    frc_prediv #(.RATIO_MAX(RATIO_MAX)) u_prediv (
        .clk(clk), .rst_n(rst_n), .ratio(st_q.ratio), .tick_o(tick_w)
    );

    frc_frame #(.FRAME_TICKS(FRAME_TICKS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .frame_o(frame_w)
    );

    always_comb begin
        st_d = st_q;
        if (frame_w && st_q.pend_v) begin
            st_d.ratio  = st_q.pend;
            st_d.pend_v = 1'b0;
        end
        if (done_w) begin
            st_d.pend   = ratio_new_w;
            st_d.pend_v = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ratio: RW'(RATIO_RST), pend: RW'(RATIO_RST), pend_v: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o = st_q.ratio;
    assign tick_o  = tick_w;
    assign frame_o = frame_w;

    AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_o >= RW'(RATIO_MIN)) && (ratio_o <= RW'(RATIO_MAX))); // R2
    AST_RATIO_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_o != $past(ratio_o)) |-> $past(frame_o)); // R9
    AST_FRAME_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o |-> tick_o); // R8

endmodule

// File: tb/tb_frame_rate_cal.sv
module tb_frame_rate_cal;
    localparam int CW = 9;
    localparam int FT = 4;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_en = 1'b0;
    logic       pwr_down = 1'b0;
    logic       partial = 1'b0;
    logic [3:0] ratio_o;
    logic       tick_o;
    logic       frame_o;

    int checks = 0;
    int errors = 0;

    frame_rate_cal #(.CNT_W(CW), .FRAME_TICKS(FT)) dut (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .pwr_down(pwr_down),
        .partial(partial), .ratio_o(ratio_o), .tick_o(tick_o), .frame_o(frame_o)
    );

    always #5 clk = ~clk;

    // Behavioural reference, advanced on each rising edge.
    int m_ratio, m_pend, m_div, m_fc, m_cnt;
    bit m_pv, m_run, m_prev, m_tick, m_frame;

    function automatic int expect_ratio(input int n);
        int r;
        r = (n + 8) / 16;
        if (r < 1) r = 1;
        if (r > 15) r = 15;
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ratio = 4; m_pend = 4; m_pv = 0; m_div = 0; m_fc = 0;
            m_cnt = 0; m_run = 0; m_prev = 0;
        end else begin
            bit blk, fin;
            int newr;
            blk = pwr_down || partial;
            fin = 0;
            newr = 0;
            m_tick  = (m_div == m_ratio - 1);
            m_frame = m_tick && (m_fc == FT - 1);
            if (m_run) begin
                if (blk) m_run = 0;
                else if (cal_en) begin
                    if (m_cnt < (1 << CW) - 1) m_cnt++;
                end else begin
                    m_run = 0; fin = 1; newr = expect_ratio(m_cnt);
                end
            end else if (cal_en && !m_prev && !blk) begin
                m_run = 1; m_cnt = 1;
            end
            if (m_frame && m_pv) begin
                m_ratio = m_pend; m_pv = 0;
            end
            if (fin) begin
                m_pend = newr; m_pv = 1;
            end
            if (m_tick) begin
                m_div = 0;
                m_fc = (m_fc == FT - 1) ? 0 : m_fc + 1;
            end else m_div++;
            m_prev = cal_en;
        end
    end

    // Per-cycle comparison against the model (R2, R8, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            bit et, ef;
            et = (m_div == m_ratio - 1);
            ef = et && (m_fc == FT - 1);
            checks++;
            if (ratio_o != m_ratio[3:0] || tick_o != et || frame_o != ef) begin
                errors++;
                $display("FAIL R2/R8/R9 model t=%0t ratio=%0d tick=%0b frame=%0b exp ratio=%0d tick=%0b frame=%0b",
                         $time, ratio_o, tick_o, frame_o, m_ratio, et, ef);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic window(input int n);
        @(negedge clk);
        cal_en = 1'b1;
        repeat (n) @(negedge clk);
        cal_en = 1'b0;
    endtask

    // Waits for a frame strobe, then for the clock on which ratio updates.
    task automatic to_frame_after();
        do @(negedge clk); while (!frame_o);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) to_frame_after();
    endtask

    initial begin
        #(WATCHDOG_CYC * 10);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int gap;
        int old;
        repeat (3) @(negedge clk);
        check("R1 reset ratio", ratio_o, 4);
        check("R1 reset tick", tick_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 first tick on 4th clock", tick_o, 1);

        // R3 + R9: 96 cycles gives 6, held until a frame.
        window(96);
        old = ratio_o;
        while (!frame_o) begin
            check("R9 ratio held before frame", ratio_o, old);
            @(negedge clk);
        end
        @(negedge clk);
        check("R3 R9 ratio after frame (96 cycles)", ratio_o, 6);

        // R8: tick spacing equals ratio.
        while (!tick_o) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tick_o);
        check("R8 tick spacing", gap, 6);

        // R3 rounding boundaries.
        window(71); to_frame_after();
        check("R3 71 cycles rounds to 4", ratio_o, 4);
        window(72); to_frame_after();
        check("R3 72 cycles rounds to 5", ratio_o, 5);
        window(64); to_frame_after();
        check("R3 64 cycles gives 4", ratio_o, 4);

        // R4: short windows.
        window(5); to_frame_after();
        check("R4 5 cycles gives 1", ratio_o, 1);
        window(8); to_frame_after();
        check("R4 8 cycles gives 1", ratio_o, 1);
        window(40); to_frame_after();
        check("R3 40 cycles gives 3", ratio_o, 3);

        // R5: saturation, no wrap.
        window(600); to_frame_after();
        check("R5 600 cycles saturates to 15", ratio_o, 15);
        window(250); to_frame_after();
        check("R5 250 cycles gives 15", ratio_o, 15);
        window(48); to_frame_after();
        check("R3 48 cycles gives 3", ratio_o, 3);

        // R6: rising edge during power-down is ignored.
        @(negedge clk); pwr_down = 1'b1;
        window(100);
        @(negedge clk); pwr_down = 1'b0;
        settle();
        check("R6 power-down blocks start", ratio_o, 3);

        // R6: rising edge during partial mode is ignored.
        @(negedge clk); partial = 1'b1;
        window(150);
        @(negedge clk); partial = 1'b0;
        settle();
        check("R6 partial blocks start", ratio_o, 3);

        // R7: abort mid-window.
        @(negedge clk); cal_en = 1'b1;
        repeat (50) @(negedge clk);
        pwr_down = 1'b1;
        @(negedge clk); pwr_down = 1'b0;
        repeat (50) @(negedge clk);
        cal_en = 1'b0;
        settle();
        check("R7 power-down abort keeps ratio", ratio_o, 3);

        @(negedge clk); cal_en = 1'b1;
        repeat (30) @(negedge clk);
        partial = 1'b1;
        repeat (2) @(negedge clk);
        cal_en = 1'b0; partial = 1'b0;
        settle();
        check("R7 partial abort keeps ratio", ratio_o, 3);

        // R10: enable already high when the block clears.
        @(negedge clk); partial = 1'b1; cal_en = 1'b1;
        repeat (3) @(negedge clk);
        partial = 1'b0;
        repeat (120) @(negedge clk);
        cal_en = 1'b0;
        settle();
        check("R10 level without edge starts nothing", ratio_o, 3);

        // Recovery after the blocked cases.
        window(32); to_frame_after();
        check("R3 32 cycles gives 2", ratio_o, 2);
        settle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule